// File: doc/BRIEF.md
# Banked-Stack Register Bank

This block holds the architectural register state of a small processor core. Sixteen 32-bit registers are addressed by a 4-bit index. Two read ports and one write port serve the execute stage. Indexes 0 to 12 hold general data. Index 14 is the link register, which a subroutine call loads with its return address. A read of index 15 gives the address of the current instruction plus a fixed pipeline offset of 4; nothing is stored there.

Index 13 is the stack pointer, but two physical copies sit behind it: a main copy and a process copy. The process copy is chosen only when the control bit selects it and the core runs in thread mode. Handler mode always uses the main copy. A separate special-register port names a physical copy directly, so software can read or load the copy that index 13 does not reach. Both copies are kept word aligned.

Each read port also takes a compact-field flag. With the flag set, the port sees only the low group, registers 0 to 7.

Top module: `regbank_core`

## Requirements
- R1: After reset, registers 0 to 12, the link register and the process stack pointer read as zero. The main stack pointer reads as the parameter SP_INIT.
- R2: A read of index 0 to 12 or 14 returns the stored value. Each read port is independent of the other.
- R3: Index 13 resolves to the process stack pointer only when ctrl_spsel is 1 and handler_mode is 0. In every other case it resolves to the main stack pointer.
- R4: A write to index 13 changes only the copy that index 13 resolves to in that cycle. The other copy keeps its value.
- R5: The special-register port addresses a copy with spr_which: 0 is main, 1 is process. spr_rd_data returns that copy. spr_wr_en loads it. If an index-13 write hits the same copy in the same cycle, the special-register write wins.
- R6: Any write to either stack pointer stores the data with bits [1:0] cleared.
- R7: call_en loads call_ret_addr into the link register. When a wr_en write to index 14 happens in the same cycle, call_en takes priority.
- R8: A read of index 15 returns pc_cur + 4. A write to index 15 changes no register.
- R9: When rd_a_low or rd_b_low is set, that port uses only the index bits [2:0], so it reaches registers 0 to 7 only.
- R10: A read of the physical register being written in the same cycle returns the new value. This holds for both read ports and for the special-register read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_low | input | 1 | Port A uses the 3-bit low-group field |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_low | input | 1 | Port B uses the 3-bit low-group field |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port index |
| wr_data | input | 32 | Write port data |
| call_en | input | 1 | Subroutine call: load the link register |
| call_ret_addr | input | 32 | Return address for the link register |
| pc_cur | input | 32 | Address of the executing instruction |
| handler_mode | input | 1 | 1 while an exception handler runs |
| ctrl_spsel | input | 1 | Control bit that selects the process stack in thread mode |
| spr_which | input | 1 | Special-register port target: 0 main, 1 process |
| spr_wr_en | input | 1 | Special-register port write enable |
| spr_wr_data | input | 32 | Special-register port write data |
| spr_rd_data | output | 32 | Special-register port read data |

## Verification
All three read outputs are combinational. Because of the write-first bypass, each one already shows the effect of the write presented in the same cycle. The registered state moves on at the next rising edge and appears in the reads of the following cycle. The bench drives inputs just after the falling edge and samples 1 ns later, well before the rising edge. It compares the outputs against a model's next-state image built from the same inputs, then commits that image after the edge. This gives zero-cycle checking for the bypass and one-cycle checking for stored values.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int XLEN   = 32;
  localparam int IDX_W  = 4;
  localparam int NREG   = 1 << IDX_W;
  localparam int LOW_W  = 3;
  localparam int SP_IDX = 13;
  localparam int LR_IDX = 14;
  localparam int PC_IDX = 15;

  typedef logic [XLEN-1:0]  word_t;
  typedef logic [IDX_W-1:0] ridx_t;

  // restrict an index to the low group when the compact field is in use
  function automatic ridx_t eff_index(input ridx_t idx, input logic low);
    return low ? ridx_t'(idx[LOW_W-1:0]) : idx;
  endfunction

  // stack pointer stores are word aligned
  function automatic word_t sp_align(input word_t d);
    return {d[XLEN-1:2], 2'b00};
  endfunction

  // value seen when reading the program counter index
  function automatic word_t pc_view(input word_t pc, input int unsigned ofs);
    return pc + word_t'(ofs);
  endfunction

  // process stack in use only for thread code with the control bit set
  function automatic logic sp_pick(input logic spsel, input logic handler);
    return spsel & ~handler;
  endfunction
endpackage

// File: rtl/rb_sp_bank.sv
module rb_sp_bank
  import regbank_pkg::*;
#(
  parameter word_t SP_INIT = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  use_psp,
  input  logic  gp_we,
  input  word_t gp_wd,
  input  logic  spr_we,
  input  logic  spr_which,
  input  word_t spr_wd,
  output word_t sp_view,
  output word_t spr_view
);
  word_t msp_q, psp_q, msp_d, psp_d;
  logic  msp_we, psp_we, msp_by_spr, psp_by_spr;

  always_comb begin
    msp_by_spr = spr_we && !spr_which;
    psp_by_spr = spr_we &&  spr_which;
    msp_we     = msp_by_spr || (gp_we && !use_psp);
    psp_we     = psp_by_spr || (gp_we &&  use_psp);
    msp_d = msp_we ? sp_align(msp_by_spr ? spr_wd : gp_wd) : msp_q;
    psp_d = psp_we ? sp_align(psp_by_spr ? spr_wd : gp_wd) : psp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msp_q <= sp_align(SP_INIT);
      psp_q <= '0;
    end else begin
      msp_q <= msp_d;
      psp_q <= psp_d;
    end
  end

  assign sp_view  = use_psp   ? psp_d : msp_d;
  assign spr_view = spr_which ? psp_d : msp_d;

  // R6
  sp_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msp_q[1:0] == 2'b00) && (psp_q[1:0] == 2'b00));

  // R4
  msp_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gp_we && use_psp && !spr_we) |=> $stable(msp_q));

  // R4
  psp_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gp_we && !use_psp && !spr_we) |=> $stable(psp_q));

  // R5
  spr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_we && spr_which) |=> (psp_q == sp_align($past(spr_wd))));
endmodule

// File: rtl/rb_gpr_file.sv
module rb_gpr_file
  import regbank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  ridx_t widx,
  input  word_t wd,
  input  logic  call_en,
  input  word_t call_ra,
  output word_t [NREG-1:0] view
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == SP_IDX || i == PC_IDX) begin : g_hole
      assign view[i] = '0;
    end else begin : g_store
      word_t q, d;
      logic  hit;
      assign hit = we && (widx == ridx_t'(i));
      if (i == LR_IDX) begin : g_lr
        assign d = call_en ? call_ra : (hit ? wd : q);
        // R7
        lr_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
          call_en |=> (q == $past(call_ra)));
      end else begin : g_gp
        assign d = hit ? wd : q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign view[i] = d;
    end
  end
endmodule

// File: rtl/rb_rd_port.sv
module rb_rd_port
  import regbank_pkg::*;
#(
  parameter int unsigned PC_OFS = 4
) (
  input  ridx_t idx,
  input  logic  low,
  input  word_t [NREG-1:0] gpr_view,
  input  word_t sp_view,
  input  word_t pc,
  output word_t data
);
  ridx_t e;
  always_comb begin
    e = eff_index(idx, low);
    if (e == ridx_t'(SP_IDX))      data = sp_view;
    else if (e == ridx_t'(PC_IDX)) data = pc_view(pc, PC_OFS);
    else                           data = gpr_view[e];
  end
endmodule

// File: rtl/regbank_core.sv
module regbank_core
  import regbank_pkg::*;
#(
  parameter logic [31:0] SP_INIT = 32'h2000_0400,
  parameter int unsigned PC_OFS  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  rd_a_idx,
  input  logic        rd_a_low,
  output logic [31:0] rd_a_data,
  input  logic [3:0]  rd_b_idx,
  input  logic        rd_b_low,
  output logic [31:0] rd_b_data,
  input  logic        wr_en,
  input  logic [3:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic        call_en,
  input  logic [31:0] call_ret_addr,
  input  logic [31:0] pc_cur,
  input  logic        handler_mode,
  input  logic        ctrl_spsel,
  input  logic        spr_which,
  input  logic        spr_wr_en,
  input  logic [31:0] spr_wr_data,
  output logic [31:0] spr_rd_data
);
  logic  use_psp, sp_we;
  word_t sp_view;
  word_t [NREG-1:0] gpr_view;

  assign use_psp = sp_pick(ctrl_spsel, handler_mode);
  assign sp_we   = wr_en && (wr_idx == ridx_t'(SP_IDX));

  rb_gpr_file u_gpr (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .widx(wr_idx), .wd(wr_data),
    .call_en(call_en), .call_ra(call_ret_addr), .view(gpr_view)
  );

  rb_sp_bank #(.SP_INIT(SP_INIT)) u_sp (
    .clk(clk), .rst_n(rst_n), .use_psp(use_psp), .gp_we(sp_we), .gp_wd(wr_data),
    .spr_we(spr_wr_en), .spr_which(spr_which), .spr_wd(spr_wr_data),
    .sp_view(sp_view), .spr_view(spr_rd_data)
  );

  rb_rd_port #(.PC_OFS(PC_OFS)) u_rda (
    .idx(rd_a_idx), .low(rd_a_low), .gpr_view(gpr_view), .sp_view(sp_view),
    .pc(pc_cur), .data(rd_a_data)
  );

  rb_rd_port #(.PC_OFS(PC_OFS)) u_rdb (
    .idx(rd_b_idx), .low(rd_b_low), .gpr_view(gpr_view), .sp_view(sp_view),
    .pc(pc_cur), .data(rd_b_data)
  );

  // R3
  handler_uses_msp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (handler_mode && rd_a_idx == 4'd13 && !rd_a_low && !spr_which)
      |-> (rd_a_data == spr_rd_data));

  // R8
  pc_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == 4'd15 && !rd_b_low) |-> (rd_b_data == pc_cur + 32'd4));

  // R10
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == rd_a_idx && wr_idx < 4'd13 && !rd_a_low)
      |-> (rd_a_data == wr_data));
endmodule

// File: tb/sim_regbank_core.sv
`timescale 1ns/1ps
module sim_regbank_core;
  localparam logic [31:0] SPI = 32'h2000_0400;

  logic clk = 0, rst_n = 0;
  logic [3:0] rd_a_idx, rd_b_idx, wr_idx;
  logic rd_a_low, rd_b_low, wr_en, call_en, handler_mode, ctrl_spsel, spr_which, spr_wr_en;
  logic [31:0] wr_data, call_ret_addr, pc_cur, spr_wr_data;
  logic [31:0] rd_a_data, rd_b_data, spr_rd_data;

  int nchk = 0, nerr = 0;
  bit done = 0;

  logic [31:0] mg [16];
  logic [31:0] ng [16];
  logic [31:0] msp, psp, nmsp, npsp;

  always #5 clk = ~clk;

  regbank_core #(.SP_INIT(SPI)) u0 (.*);

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic upsp();
    return ctrl_spsel && !handler_mode;
  endfunction

  task automatic build_next();
    for (int i = 0; i < 16; i++) ng[i] = mg[i];
    nmsp = msp; npsp = psp;
    if (wr_en && (wr_idx < 13 || wr_idx == 14)) ng[wr_idx] = wr_data;
    if (call_en) ng[14] = call_ret_addr;
    if (wr_en && wr_idx == 13) begin
      if (upsp()) npsp = wr_data & ~32'h3; else nmsp = wr_data & ~32'h3;
    end
    if (spr_wr_en) begin
      if (spr_which) npsp = spr_wr_data & ~32'h3; else nmsp = spr_wr_data & ~32'h3;
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [3:0] idx, logic low);
    logic [3:0] e;
    e = low ? {1'b0, idx[2:0]} : idx;
    if (e == 13) return upsp() ? npsp : nmsp;
    if (e == 15) return pc_cur + 32'd4;
    return ng[e];
  endfunction

  function automatic string auto_tag(logic [3:0] idx, logic low);
    if (low) return "R9";
    if (idx == 13) return "R3";
    if (idx == 15) return "R8";
    return "R2";
  endfunction

  // drive phase is done by caller after negedge; this checks then commits
  task automatic cyc(string tag);
    #1;
    build_next();
    chk(tag == "" ? auto_tag(rd_a_idx, rd_a_low) : tag, "port A", rd_a_data, exp_rd(rd_a_idx, rd_a_low));
    chk(tag == "" ? auto_tag(rd_b_idx, rd_b_low) : tag, "port B", rd_b_data, exp_rd(rd_b_idx, rd_b_low));
    chk(tag == "" ? "R5" : tag, "spr port", spr_rd_data, spr_which ? npsp : nmsp);
    @(posedge clk);
    for (int i = 0; i < 16; i++) mg[i] = ng[i];
    msp = nmsp; psp = npsp;
    @(negedge clk);
  endtask

  task automatic idle();
    rd_a_idx = 0; rd_b_idx = 0; rd_a_low = 0; rd_b_low = 0;
    wr_en = 0; wr_idx = 0; wr_data = 0; call_en = 0; call_ret_addr = 0;
    pc_cur = 32'h0000_0100; handler_mode = 0; ctrl_spsel = 0;
    spr_which = 0; spr_wr_en = 0; spr_wr_data = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    for (int i = 0; i < 16; i++) mg[i] = 0;
    msp = SPI; psp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset state through every index, both ports, both spr targets
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i); spr_which = i[0];
      cyc(i == 15 ? "R8" : "R1");
    end
    idle(); ctrl_spsel = 1; rd_a_idx = 13; cyc("R1");

    // R10: same-cycle write then read back R2
    idle(); wr_en = 1; wr_idx = 5; wr_data = 32'hCAFE_0005; rd_a_idx = 5; rd_b_idx = 5; cyc("R10");
    idle(); rd_a_idx = 5; rd_b_idx = 0; cyc("R2");

    // R3/R6: thread + spsel write to 13 goes to process copy, aligned
    idle(); ctrl_spsel = 1; wr_en = 1; wr_idx = 13; wr_data = 32'h1000_0007; rd_a_idx = 13; spr_which = 1; cyc("R6");
    // R4: handler view still shows untouched main copy
    idle(); ctrl_spsel = 1; handler_mode = 1; rd_a_idx = 13; spr_which = 0; cyc("R4");
    idle(); ctrl_spsel = 0; rd_a_idx = 13; spr_which = 1; cyc("R3");
    // R4: main write leaves process copy
    idle(); wr_en = 1; wr_idx = 13; wr_data = 32'h3000_00FF; rd_a_idx = 13; spr_which = 1; cyc("R4");

    // R5: load inactive copy through spr port, then conflict
    idle(); spr_wr_en = 1; spr_which = 1; spr_wr_data = 32'h4444_4443; cyc("R5");
    idle(); ctrl_spsel = 1; rd_a_idx = 13; cyc("R5");
    idle(); ctrl_spsel = 1; wr_en = 1; wr_idx = 13; wr_data = 32'h1111_1110;
    spr_wr_en = 1; spr_which = 1; spr_wr_data = 32'h2222_2222; rd_a_idx = 13; cyc("R5");
    idle(); ctrl_spsel = 1; rd_a_idx = 13; spr_which = 1; cyc("R5");

    // R7: call beats write to link register
    idle(); call_en = 1; call_ret_addr = 32'h0000_0ABD; wr_en = 1; wr_idx = 14; wr_data = 32'h5555_5555; rd_a_idx = 14; cyc("R7");
    idle(); rd_b_idx = 14; cyc("R7");

    // R8: write to 15 has no effect
    idle(); wr_en = 1; wr_idx = 15; wr_data = 32'hDEAD_BEEF; pc_cur = 32'h0000_2000; rd_a_idx = 15; cyc("R8");
    for (int i = 0; i < 16; i++) begin idle(); rd_a_idx = 4'(i); cyc("R8"); end

    // R9: compact field on 10 reaches register 2
    idle(); wr_en = 1; wr_idx = 2; wr_data = 32'h0000_0222; cyc("R2");
    idle(); wr_en = 1; wr_idx = 10; wr_data = 32'h0000_0AAA; cyc("R2");
    idle(); rd_a_idx = 10; rd_a_low = 1; rd_b_idx = 10; cyc("R9");
    idle(); rd_a_idx = 15; rd_a_low = 1; cyc("R9");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
      rd_a_low = ($urandom % 4) == 0; rd_b_low = ($urandom % 4) == 0;
      wr_en = $urandom; wr_idx = 4'($urandom); wr_data = $urandom;
      call_en = ($urandom % 8) == 0; call_ret_addr = $urandom;
      pc_cur = $urandom; handler_mode = $urandom; ctrl_spsel = $urandom;
      spr_which = $urandom; spr_wr_en = ($urandom % 6) == 0; spr_wr_data = $urandom;
      cyc("");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule